// File: doc/BRIEF.md
# Memory Device Command Front End with Bank State Tracking

This block is the command side of a DDR3-style memory device model, in one clock domain. On every rising clock edge it samples the chip-select, row-strobe, column-strobe, write-enable, bank, address and clock-enable inputs. It decodes one command per cycle. It keeps an open/closed flag and the open row for each bank. It holds shadow copies of the four mode registers.

For each accepted read or write it reports the bank, the row, the column, the burst length and the auto-precharge flag as a one-cycle access pulse. Commands that do not fit the bank state are rejected with a one-cycle error pulse. The block also follows the device power state, which changes when clock enable falls or rises. It gates the termination enable with the termination setting in the mode registers.

All registered outputs change on the clock edge that samples the command. The one exception is the reported power state during self-refresh exit, which follows clock enable without waiting for an edge.

Top module: `ddr_cmd_front`

## Requirements
- R1: With cs_n high the command is a deselect. With cs_n low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, 111 no-op and 110 reserved. cmd_code shows the command sampled at the last edge, coded as deselect 0, no-op 1, activate 2, read 3, write 4, precharge 5, refresh 6, mode load 7 and reserved 8.
- R2: An activate to a closed bank sets that bank's bit in bank_open (bit index equals bank number) and records the address bus as that bank's open row.
- R3: A read or write to an open bank raises acc_valid for one cycle. acc_write is high for a write. acc_bank gives the bank, acc_row gives the stored row and acc_col gives addr[9:0].
- R4: On a read or write, addr[10] is the auto-precharge flag (acc_autopre). When it is set, the bank's bit in bank_open is clear in the same cycle that acc_valid is high.
- R5: A precharge with addr[10] high clears every bank_open bit. With addr[10] low it clears only the bank given by ba.
- R6: acc_bl8 is set from mode register 0 bits [1:0]. Value 00 gives a burst of 8 (1). Value 10 gives a chopped burst of 4 (0). Value 01 takes addr[12] of the access (high gives 8, low gives 4).
- R7: A mode load with ba[2] low writes the address bus into mode register ba[1:0]. mr_flat shows register n in bits [16n+15:16n]. A mode load with ba[2] high changes nothing.
- R8: An activate to an open bank, or a read or write to a closed bank, raises proto_err for one cycle. In that case acc_valid stays low and bank_open and the stored rows do not change.
- R9: While active, cke sampled low with all banks closed enters precharge power-down (pwr_state 1), or self refresh (3) when the command is a refresh. With any bank open it enters active power-down (2). The command on that edge is not executed.
- R10: Outside the active state, commands are ignored. cke sampled high returns to active (0), and the command on that exit edge is also ignored. In self refresh, pwr_state reads 0 as soon as cke is high, before the next edge.
- R11: odt_on is the registered value of odt AND the termination setting. The termination setting is on when any of bits 2, 6 or 9 of mode register 1 is set, taken before any mode load on the same edge.
- R12: A synchronous active-high reset clears bank_open, all mode registers, acc_valid, proto_err and odt_on, and sets the power state to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write-enable command bit |
| ba | input | 3 | Bank address / mode register select |
| addr | input | 16 | Row, column, flags or mode opcode |
| odt | input | 1 | Termination request |
| cmd_code | output | 4 | Command decoded at the last edge |
| acc_valid | output | 1 | One-cycle accepted access pulse |
| acc_write | output | 1 | Access is a write |
| acc_bank | output | 3 | Bank of the access |
| acc_row | output | 16 | Open row of the accessed bank |
| acc_col | output | 10 | Column of the access |
| acc_bl8 | output | 1 | 1: burst of 8, 0: chopped burst of 4 |
| acc_autopre | output | 1 | Access closes its bank |
| proto_err | output | 1 | One-cycle protocol error pulse |
| bank_open | output | 8 | Per-bank open flags |
| pwr_state | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self refresh |
| odt_on | output | 1 | Gated termination enable |
| mr_flat | output | 64 | Four mode register shadows |

## Verification
Every command encoding is driven once, plus a masked activate, so that decode errors and chip-select leaks show up separately. Bank tracking is tested with several patterns: single and multiple open banks, a mix of selective and global precharges, and accesses with and without auto-precharge. Together these separate a wrong bank index from a wrong global decision. Protocol-error stimuli (re-activate, access to a closed bank) are followed by a good read, which shows the stored row survived. The burst-mode and termination tests toggle addr[12] and odt under each mode-register setting, so that a fixed result cannot pass. Power tests enter each low-power state from matching bank states, send commands that must be ignored, and check the self-refresh exit between clock edges.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_REF   = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_RSVD  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_PPD    = 2'd1,
        PWR_APD    = 2'd2,
        PWR_SREF   = 2'd3
    } pwr_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic autopre;
        logic bl8;
    } acc_flags_t;

    localparam int A_AP  = 10;   // auto-precharge / all-bank flag
    localparam int A_BC  = 12;   // per-access burst length select
    localparam logic [1:0] BLM_FIX8 = 2'b00;
    localparam logic [1:0] BLM_OTF  = 2'b01;
    localparam logic [1:0] BLM_FIX4 = 2'b10;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic [2:0] rcw);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            unique case (rcw)
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MRS;
                3'b111:  c = CMD_NOP;
                default: c = CMD_RSVD;
            endcase
        end
        return c;
    endfunction

    function automatic logic burst_is_8(input logic [1:0] mode, input logic sel_bit);
        logic r;
        unique case (mode)
            BLM_OTF:  r = sel_bit;
            BLM_FIX4: r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic is_rw(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddr_bank_tracker.sv
`timescale 1ns/1ps
module ddr_bank_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int ROW_W = 16,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec,
    input  cmd_e             cmd,
    input  logic [BA_W-1:0]  ba,
    input  logic             ap,
    input  logic [ROW_W-1:0] row_in,
    output logic [BANKS-1:0] open_vec,
    output logic [ROW_W-1:0] sel_row,
    output logic             err
);
    logic [ROW_W-1:0] row_q [BANKS];
    logic [BANKS-1:0] open_q;
    logic             sel_open;

    assign sel_open = open_q[ba];
    assign sel_row  = row_q[ba];
    assign err = exec && (((cmd == CMD_ACT) && sel_open) ||
                          (is_rw(cmd) && !sel_open));

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic hit, set_b, clr_b;
        assign hit   = (ba == BA_W'(i));
        assign set_b = exec && (cmd == CMD_ACT) && hit && !open_q[i];
        assign clr_b = exec && (((cmd == CMD_PRE) && (ap || hit)) ||
                                (is_rw(cmd) && hit && open_q[i] && ap));
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[i] <= 1'b0;
                row_q[i]  <= '0;
            end else if (set_b) begin
                open_q[i] <= 1'b1;
                row_q[i]  <= row_in;
            end else if (clr_b) begin
                open_q[i] <= 1'b0;
            end
        end
    end

    assign open_vec = open_q;
endmodule

// File: rtl/ddr_mode_shadow.sv
`timescale 1ns/1ps
module ddr_mode_shadow
    import ddr_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BA_W   = 3,
    parameter int NUM_MR = 4,
    localparam int SEL_W = $clog2(NUM_MR)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     exec,
    input  cmd_e                     cmd,
    input  logic [BA_W-1:0]          ba,
    input  logic [ADDR_W-1:0]        addr,
    output logic [NUM_MR*ADDR_W-1:0] mr_flat,
    output logic [1:0]               bl_mode,
    output logic                     term_en
);
    logic [ADDR_W-1:0] mr_q [NUM_MR];
    logic              upper_zero;

    assign upper_zero = ((ba >> SEL_W) == '0);

    for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
        logic wr_i;
        assign wr_i = exec && (cmd == CMD_MRS) && upper_zero &&
                      (ba[SEL_W-1:0] == SEL_W'(i));
        always_ff @(posedge clk) begin
            if (rst)       mr_q[i] <= '0;
            else if (wr_i) mr_q[i] <= addr;
        end
        assign mr_flat[i*ADDR_W +: ADDR_W] = mr_q[i];
    end

    assign bl_mode = mr_q[0][1:0];
    assign term_en = mr_q[1][2] | mr_q[1][6] | mr_q[1][9];
endmodule

// File: rtl/ddr_power_fsm.sv
`timescale 1ns/1ps
module ddr_power_fsm
    import ddr_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e cmd,
    input  logic all_idle,
    output pwr_e pwr_q,
    output pwr_e pwr_view,
    output logic exec
);
    pwr_e pwr_d;

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PWR_ACTIVE: begin
                if (!cke) begin
                    if (!all_idle)             pwr_d = PWR_APD;
                    else if (cmd == CMD_REF)   pwr_d = PWR_SREF;
                    else                       pwr_d = PWR_PPD;
                end
            end
            default: if (cke) pwr_d = PWR_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pwr_q <= PWR_ACTIVE;
        else     pwr_q <= pwr_d;
    end

    // self-refresh exit follows clock enable without an edge
    assign pwr_view = ((pwr_q == PWR_SREF) && cke) ? PWR_ACTIVE : pwr_q;
    assign exec     = (pwr_q == PWR_ACTIVE) && cke;
endmodule

// File: rtl/ddr_cmd_front.sv
`timescale 1ns/1ps
module ddr_cmd_front
    import ddr_cmd_pkg::*;
#(
    parameter int BANKS  = 8,
    parameter int ADDR_W = 16,
    parameter int COL_W  = 10,
    parameter int NUM_MR = 4,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cke,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [BA_W-1:0]          ba,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     odt,
    output logic [3:0]               cmd_code,
    output logic                     acc_valid,
    output logic                     acc_write,
    output logic [BA_W-1:0]          acc_bank,
    output logic [ADDR_W-1:0]        acc_row,
    output logic [COL_W-1:0]         acc_col,
    output logic                     acc_bl8,
    output logic                     acc_autopre,
    output logic                     proto_err,
    output logic [BANKS-1:0]         bank_open,
    output logic [1:0]               pwr_state,
    output logic                     odt_on,
    output logic [NUM_MR*ADDR_W-1:0] mr_flat
);
    cmd_e              cmd_now, cmd_q;
    pwr_e              pwr_q, pwr_view;
    logic              exec, trk_err, err_q, term_en, odt_q, take_acc;
    logic [1:0]        bl_mode;
    logic [ADDR_W-1:0] sel_row, row_q;
    logic [BA_W-1:0]   bank_q;
    logic [COL_W-1:0]  col_q;
    acc_flags_t        acc_q;

    assign cmd_now  = decode_cmd(cs_n, {ras_n, cas_n, we_n});
    assign take_acc = exec && is_rw(cmd_now) && !trk_err;

    ddr_power_fsm u_pwr (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .cmd      (cmd_now),
        .all_idle (bank_open == '0),
        .pwr_q    (pwr_q),
        .pwr_view (pwr_view),
        .exec     (exec)
    );

    ddr_bank_tracker #(.BANKS(BANKS), .ROW_W(ADDR_W)) u_banks (
        .clk      (clk),
        .rst      (rst),
        .exec     (exec),
        .cmd      (cmd_now),
        .ba       (ba),
        .ap       (addr[A_AP]),
        .row_in   (addr),
        .open_vec (bank_open),
        .sel_row  (sel_row),
        .err      (trk_err)
    );

    ddr_mode_shadow #(.ADDR_W(ADDR_W), .BA_W(BA_W), .NUM_MR(NUM_MR)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .exec    (exec),
        .cmd     (cmd_now),
        .ba      (ba),
        .addr    (addr),
        .mr_flat (mr_flat),
        .bl_mode (bl_mode),
        .term_en (term_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_DESEL;
            err_q  <= 1'b0;
            acc_q  <= '0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            odt_q  <= 1'b0;
        end else begin
            cmd_q       <= cmd_now;
            err_q       <= trk_err;
            odt_q       <= odt && term_en;
            acc_q.valid <= take_acc;
            if (take_acc) begin
                acc_q.write   <= (cmd_now == CMD_WR);
                acc_q.autopre <= addr[A_AP];
                acc_q.bl8     <= burst_is_8(bl_mode, addr[A_BC]);
                bank_q        <= ba;
                row_q         <= sel_row;
                col_q         <= addr[COL_W-1:0];
            end
        end
    end

    assign cmd_code    = cmd_q;
    assign proto_err   = err_q;
    assign acc_valid   = acc_q.valid;
    assign acc_write   = acc_q.write;
    assign acc_autopre = acc_q.autopre;
    assign acc_bl8     = acc_q.bl8;
    assign acc_bank    = bank_q;
    assign acc_row     = row_q;
    assign acc_col     = col_q;
    assign odt_on      = odt_q;
    assign pwr_state   = pwr_view;
endmodule

// File: rtl/ddr_cmd_front_chk.sv
`timescale 1ns/1ps
module ddr_cmd_front_chk #(
    parameter int BANKS = 8,
    parameter int BA_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             proto_err,
    input logic             acc_valid,
    input logic             acc_autopre,
    input logic [BA_W-1:0]  acc_bank,
    input logic [BANKS-1:0] bank_open,
    input logic [1:0]       pwr_q,
    input logic             odt,
    input logic             odt_on
);
    p_err_no_access_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !acc_valid);

    p_autopre_closed_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_autopre) |-> !bank_open[acc_bank]);

    p_access_bank_open_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_autopre) |-> bank_open[acc_bank]);

    p_sref_all_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_q == 2'd3 && $past(pwr_q) != 2'd3) |-> (bank_open == '0));

    p_lowpower_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_q) != 2'd0) |-> $stable(bank_open));

    p_no_access_lowpower_r10: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ($past(pwr_q) == 2'd0));

    p_odt_needs_request_r11: assert property (@(posedge clk) disable iff (rst)
        odt_on |-> $past(odt));
endmodule

bind ddr_cmd_front ddr_cmd_front_chk #(.BANKS(BANKS), .BA_W(BA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .proto_err   (proto_err),
    .acc_valid   (acc_valid),
    .acc_autopre (acc_autopre),
    .acc_bank    (acc_bank),
    .bank_open   (bank_open),
    .pwr_q       (pwr_q),
    .odt         (odt),
    .odt_on      (odt_on)
);

// File: tb/ddr_cmd_front_tb.sv
`timescale 1ns/1ps
module ddr_cmd_front_tb_top;
    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                           C_NOP = 3'b111, C_RSV = 3'b110;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, odt = 1'b0;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;
    logic [3:0]  cmd_code;
    logic        acc_valid, acc_write, acc_bl8, acc_autopre, proto_err, odt_on;
    logic [2:0]  acc_bank;
    logic [15:0] acc_row;
    logic [9:0]  acc_col;
    logic [7:0]  bank_open;
    logic [1:0]  pwr_state;
    logic [63:0] mr_flat;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_front dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .odt(odt),
        .cmd_code(cmd_code), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_bank(acc_bank), .acc_row(acc_row), .acc_col(acc_col),
        .acc_bl8(acc_bl8), .acc_autopre(acc_autopre), .proto_err(proto_err),
        .bank_open(bank_open), .pwr_state(pwr_state), .odt_on(odt_on),
        .mr_flat(mr_flat)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(input logic k, input logic cs, input logic [2:0] c,
                         input logic [2:0] b, input logic [15:0] a);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        odt = 1'b1;
        rst = 1'b1;
        repeat (3) drive(1, 0, C_NOP, 0, 0);
        rst = 1'b0;
        odt = 1'b0;
        check("R12 bank_open", 64'(bank_open), 0);
        check("R12 pwr_state", 64'(pwr_state), 0);
        check("R12 mr_flat", mr_flat, 0);
        check("R12 acc_valid", 64'(acc_valid), 0);
        check("R12 proto_err", 64'(proto_err), 0);
        check("R12 odt_on", 64'(odt_on), 0);
    endtask

    task automatic t_decode();
        drive(1, 0, C_NOP, 0, 0);      check("R1 nop", 64'(cmd_code), 1);
        drive(1, 0, C_REF, 0, 0);      check("R1 ref", 64'(cmd_code), 6);
        drive(1, 0, C_MRS, 0, 0);      check("R1 mrs", 64'(cmd_code), 7);
        drive(1, 0, C_RSV, 0, 0);      check("R1 rsvd", 64'(cmd_code), 8);
        drive(1, 0, C_PRE, 0, 0);      check("R1 pre", 64'(cmd_code), 5);
        drive(1, 0, C_ACT, 0, 16'h0011); check("R1 act", 64'(cmd_code), 2);
        drive(1, 0, C_RD, 0, 0);       check("R1 rd", 64'(cmd_code), 3);
        drive(1, 0, C_WR, 0, 0);       check("R1 wr", 64'(cmd_code), 4);
        drive(1, 1, C_ACT, 1, 0);      check("R1 deselect code", 64'(cmd_code), 0);
        check("R1 masked act", 64'(bank_open), 8'h01);
        drive(1, 0, C_PRE, 0, 16'h0400); check("R5 pre all", 64'(bank_open), 0);
    endtask

    task automatic t_access();
        drive(1, 0, C_ACT, 3, 16'h1234); check("R2 act opens", 64'(bank_open), 8'h08);
        drive(1, 0, C_RD, 3, 16'h005A);
        check("R3 rd valid", 64'(acc_valid), 1);
        check("R3 rd dir", 64'(acc_write), 0);
        check("R3 rd bank", 64'(acc_bank), 3);
        check("R3 rd row", 64'(acc_row), 16'h1234);
        check("R3 rd col", 64'(acc_col), 10'h05A);
        check("R6 default bl8", 64'(acc_bl8), 1);
        check("R4 no autopre", 64'(acc_autopre), 0);
        drive(1, 0, C_WR, 3, 16'h1001);
        check("R3 wr dir", 64'(acc_write), 1);
        check("R3 wr col", 64'(acc_col), 10'h001);
        check("R3 bank kept", 64'(bank_open), 8'h08);
        drive(1, 0, C_NOP, 0, 0); check("R3 pulse ends", 64'(acc_valid), 0);
    endtask

    task automatic t_errors();
        drive(1, 0, C_ACT, 3, 16'h0777);
        check("R8 reopen err", 64'(proto_err), 1);
        check("R8 reopen no acc", 64'(acc_valid), 0);
        check("R8 reopen banks", 64'(bank_open), 8'h08);
        drive(1, 0, C_NOP, 0, 0); check("R8 err one cycle", 64'(proto_err), 0);
        drive(1, 0, C_RD, 5, 0);
        check("R8 closed rd err", 64'(proto_err), 1);
        check("R8 closed rd no acc", 64'(acc_valid), 0);
        drive(1, 0, C_RD, 3, 0);
        check("R8 row kept", 64'(acc_row), 16'h1234);
        check("R8 err clears", 64'(proto_err), 0);
    endtask

    task automatic t_autopre();
        drive(1, 0, C_ACT, 5, 16'h00AB); check("R2 second bank", 64'(bank_open), 8'h28);
        drive(1, 0, C_WR, 5, 16'h0403);
        check("R4 ap valid", 64'(acc_valid), 1);
        check("R4 ap flag", 64'(acc_autopre), 1);
        check("R4 ap row", 64'(acc_row), 16'h00AB);
        check("R4 ap closes", 64'(bank_open), 8'h08);
    endtask

    task automatic t_precharge();
        drive(1, 0, C_ACT, 0, 1);
        drive(1, 0, C_ACT, 1, 2);
        drive(1, 0, C_ACT, 7, 3); check("R2 many open", 64'(bank_open), 8'h8B);
        drive(1, 0, C_PRE, 1, 0); check("R5 single", 64'(bank_open), 8'h89);
        drive(1, 0, C_PRE, 4, 0); check("R5 closed bank", 64'(bank_open), 8'h89);
        drive(1, 0, C_PRE, 2, 16'h0400); check("R5 all", 64'(bank_open), 0);
    endtask

    task automatic t_mode();
        drive(1, 0, C_MRS, 0, 16'h0001); check("R7 mr0", mr_flat, 64'h1);
        drive(1, 0, C_ACT, 2, 5);
        drive(1, 0, C_RD, 2, 16'h0000); check("R6 otf a12 low", 64'(acc_bl8), 0);
        drive(1, 0, C_RD, 2, 16'h1000); check("R6 otf a12 high", 64'(acc_bl8), 1);
        check("R6 a12 not col", 64'(acc_col), 0);
        drive(1, 0, C_MRS, 0, 16'h0002);
        drive(1, 0, C_RD, 2, 16'h1000); check("R6 fixed4", 64'(acc_bl8), 0);
        drive(1, 0, C_MRS, 4, 16'hBEEF); check("R7 ba2 ignored", mr_flat, 64'h2);
        drive(1, 0, C_MRS, 3, 16'hBEEF); check("R7 mr3", mr_flat, 64'hBEEF_0000_0000_0002);
        drive(1, 0, C_MRS, 0, 16'h0000);
        drive(1, 0, C_RD, 2, 16'h0000); check("R6 fixed8", 64'(acc_bl8), 1);
        drive(1, 0, C_PRE, 0, 16'h0400);
    endtask

    task automatic t_odt();
        odt = 1'b1;
        drive(1, 0, C_NOP, 0, 0); check("R11 term off", 64'(odt_on), 0);
        drive(1, 0, C_MRS, 1, 16'h0040); check("R11 old setting", 64'(odt_on), 0);
        drive(1, 0, C_NOP, 0, 0); check("R11 term on", 64'(odt_on), 1);
        odt = 1'b0;
        drive(1, 0, C_NOP, 0, 0); check("R11 no request", 64'(odt_on), 0);
        odt = 1'b1;
        drive(1, 0, C_MRS, 1, 16'h0000);
        drive(1, 0, C_NOP, 0, 0); check("R11 disabled again", 64'(odt_on), 0);
        odt = 1'b0;
    endtask

    task automatic t_power();
        drive(0, 1, C_NOP, 0, 0); check("R9 ppd", 64'(pwr_state), 1);
        drive(0, 0, C_ACT, 4, 0); check("R10 ppd ignores", 64'(bank_open), 0);
        drive(1, 0, C_ACT, 4, 0);
        check("R10 ppd exit", 64'(pwr_state), 0);
        check("R10 exit edge ignored", 64'(bank_open), 0);
        drive(1, 0, C_ACT, 4, 0); check("R2 after exit", 64'(bank_open), 8'h10);
        drive(0, 0, C_NOP, 0, 0); check("R9 apd", 64'(pwr_state), 2);
        drive(1, 0, C_RD, 4, 0);
        check("R10 apd exit", 64'(pwr_state), 0);
        check("R10 apd rd ignored", 64'(acc_valid), 0);
        drive(0, 0, C_REF, 0, 0); check("R9 ref with open bank", 64'(pwr_state), 2);
        drive(1, 0, C_NOP, 0, 0);
        drive(1, 0, C_PRE, 0, 16'h0400); check("R5 all before sref", 64'(bank_open), 0);
        drive(0, 0, C_REF, 0, 0); check("R9 sref", 64'(pwr_state), 3);
        drive(0, 0, C_ACT, 6, 0);
        check("R9 sref holds", 64'(pwr_state), 3);
        check("R10 sref ignores", 64'(bank_open), 0);
        cke = 1'b1;
        #1;
        check("R10 sref exit without edge", 64'(pwr_state), 0);
        @(negedge clk);
        check("R10 sref exit edge ignored", 64'(bank_open), 0);
        drive(1, 0, C_ACT, 6, 0); check("R10 active again", 64'(bank_open), 8'h40);
    endtask

    initial begin
        #200us;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_access();
        t_errors();
        t_autopre();
        t_precharge();
        t_mode();
        t_odt();
        t_power();
        summary();
    end
endmodule